// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps the contents of an asynchronous DRAM alive on behalf of a memory controller. After reset it waits out the device's power-up pause. It then performs a burst of eight refresh cycles. Only after that burst does it tell the controller that normal accesses may begin. From then on a free-running interval timer adds one owed refresh per refresh period. The block asks the memory arbiter for the bus whenever refreshes are owed. Each time it is granted, it drives the RAS and CAS strobes itself for one refresh. If the grant stays high and more refreshes are owed, it drives the next one straight after.

By default each refresh is CAS-before-RAS: CAS falls first, so the device uses its internal row counter, and write-enable is held high throughout so the device is never put into its test mode. A per-cycle select input may instead request a RAS-only refresh. In that case CAS stays high and the block supplies the row address from its own wrapping counter. Every strobe interval is converted from nanoseconds to clock cycles, rounded up, from the parameters for clock period and device timing.

Up to eight refreshes may be owed while the bus is busy, and the block raises an urgent flag when that limit is reached. If one more period elapses with the backlog still full, the retention guarantee is considered lost. The block then withdraws its ready indication and repeats the eight-cycle wake-up burst.

The controller is built around six states. ST_PWR_WAIT holds after reset until the power-up pause ends, then goes to ST_IDLE. ST_IDLE moves on when the grant is high and work is owed: to ST_CAS_LEAD for a CAS-before-RAS cycle, or to ST_ROW_LEAD for a RAS-only cycle. Both lead states go to ST_RAS_LOW when their count expires. ST_RAS_LOW goes to ST_PRECHG. ST_PRECHG returns to ST_IDLE and retires one refresh.

Top module: `dram_refresh_sched`

## Requirements
- R1: From reset, ras_n and cas_n are high and ref_req and init_done are low. ref_req first rises exactly WAKE_CYC clocks after reset is released, where WAKE_CYC = ceil(WAKE_NS / clock period).
- R2: After the pause, eight refresh cycles must complete, each marked by a one-clock ref_ack. init_done stays low until the eighth ref_ack and is high in that same clock.
- R3: A refresh cycle starts only after ref_gnt has been sampled high while ref_req is high. Without a grant, ras_n and cas_n stay high.
- R4: In a CAS-before-RAS cycle, cas_n falls exactly CSR_CYC clocks before ras_n falls, and row_oe stays low.
- R5: ras_n stays low for exactly RAS_CYC clocks, the larger of the rounded-up RAS pulse width and CAS hold time. In a CAS-before-RAS cycle, cas_n rises in the same clock as ras_n.
- R6: ras_n stays high for at least RP_CYC clocks between cycles. ref_ack is asserted exactly RP_CYC clocks after ras_n rises.
- R7: we_n is high at all times.
- R8: One refresh becomes owed every REFI_CYC clocks once the pause is over. ref_req is high while any refresh is owed, each ref_ack retires one, and ras_n and cas_n are high whenever ref_req is low.
- R9: ref_urgent is high while the wake-up burst is pending or while eight refreshes are owed. It is never high without ref_req.
- R10: If a refresh period ends while eight refreshes are already owed, init_done falls in that clock, ref_urgent stays high, and the owed count is cleared. A new burst of eight cycles is then required before init_done rises again.
- R11: With ras_only_sel high when a cycle starts, cas_n stays high for the whole cycle. row_oe is high from one clock before ras_n falls until ras_n rises, and row_addr carries a row counter. The counter starts at 0 after reset, advances by one after each RAS-only cycle, and wraps from 2^ROW_BITS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Arbiter grant; held high until ref_ack |
| ras_only_sel | input | 1 | Selects RAS-only refresh for the next cycle started |
| ref_req | output | 1 | Refresh work is owed |
| ref_urgent | output | 1 | Backlog full or wake-up burst pending |
| ref_ack | output | 1 | One-clock pulse when a refresh cycle completes |
| init_done | output | 1 | Device ready for normal accesses |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write-enable, held high |
| row_oe | output | 1 | row_addr is valid for a RAS-only refresh |
| row_addr | output | ROW_BITS | Row address for RAS-only refresh |

## Verification
The hardest situation to reach from the ports is the loss of retention, where a refresh period ends while the backlog is already full. The stimulus withholds the grant for nine refresh periods. It times the gap between the urgent flag rising and the ready indication falling, which must be exactly one period. It then grants a RAS-only burst. That burst also drives the row counter through its wrap, which the bench reaches with a narrow row parameter.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [2:0] {
        ST_PWR_WAIT,
        ST_IDLE,
        ST_CAS_LEAD,
        ST_ROW_LEAD,
        ST_RAS_LOW,
        ST_PRECHG
    } ref_state_e;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int ns_to_cycles(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_ref_tick_gen.sv
module dram_ref_tick_gen #(
    parameter int WAKE_CYC = 10000,
    parameter int REFI_CYC = 1522
) (
    input  logic clk,
    input  logic rst_n,
    output logic wait_done,
    output logic tick
);
    localparam int WW = $clog2(WAKE_CYC + 1);
    localparam int RW = $clog2(REFI_CYC + 1);

    logic [WW-1:0] wait_q;
    logic [RW-1:0] refi_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
            refi_q <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (wait_q == WW'(WAKE_CYC - 1)) done_q <= 1'b1;
            else                             wait_q <= wait_q + 1'b1;
        end else if (refi_q == RW'(REFI_CYC - 1)) begin
            refi_q <= '0;
        end else begin
            refi_q <= refi_q + 1'b1;
        end
    end

    assign wait_done = done_q;
    assign tick      = done_q && (refi_q == RW'(REFI_CYC - 1));
endmodule

// File: rtl/dram_ref_backlog.sv
module dram_ref_backlog #(
    parameter int MAX_OWED = 8,
    localparam int BW = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          consume,
    input  logic          clear,
    output logic [BW-1:0] owed,
    output logic          full,
    output logic          overflow
);
    logic [BW-1:0] owed_q;

    assign full     = (owed_q == BW'(MAX_OWED));
    assign overflow = tick && full && !consume;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else if (clear) begin
            owed_q <= '0;
        end else if (tick && !consume && !full) begin
            owed_q <= owed_q + 1'b1;
        end else if (!tick && consume && owed_q != '0) begin
            owed_q <= owed_q - 1'b1;
        end
    end

    assign owed = owed_q;
endmodule

// File: rtl/dram_ref_row_ctr.sv
module dram_ref_row_ctr #(
    parameter int ROW_BITS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    output logic [ROW_BITS-1:0] row
);
    logic [ROW_BITS-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   row_q <= '0;
        else if (adv) row_q <= row_q + 1'b1;
    end

    assign row = row_q;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_ref_pkg::*;
#(
    parameter int CLK_PS       = 10000,
    parameter int T_RAS_NS     = 60,
    parameter int T_RP_NS      = 40,
    parameter int T_CSR_NS     = 5,
    parameter int T_CHR_NS     = 10,
    parameter int WAKE_NS      = 100000,
    parameter int REFI_NS      = 15625,
    parameter int REFI_MARGIN  = 40,
    parameter int WAKE_CYCLES  = 8,
    parameter int MAX_OWED     = 8,
    parameter int ROW_BITS     = 11,
    parameter bit RAS_ONLY_EN  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_gnt,
    input  logic                ras_only_sel,
    output logic                ref_req,
    output logic                ref_urgent,
    output logic                ref_ack,
    output logic                init_done,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic                row_oe,
    output logic [ROW_BITS-1:0] row_addr
);
    localparam int RAS_CYC  = max2(ns_to_cycles(T_RAS_NS, CLK_PS), ns_to_cycles(T_CHR_NS, CLK_PS));
    localparam int RP_CYC   = ns_to_cycles(T_RP_NS, CLK_PS);
    localparam int CSR_CYC  = ns_to_cycles(T_CSR_NS, CLK_PS);
    localparam int WAKE_CYC = ns_to_cycles(WAKE_NS, CLK_PS);
    localparam int REFI_CYC = max2(ns_to_cycles(REFI_NS, CLK_PS) - REFI_MARGIN, 2);
    localparam int PH_W     = $clog2(max2(max2(RAS_CYC, RP_CYC), CSR_CYC) + 1);
    localparam int WK_W     = $clog2(WAKE_CYCLES + 1);
    localparam int BW       = $clog2(MAX_OWED + 1);

    ref_state_e          state_q, state_d;
    logic [PH_W-1:0]     ph_q, ph_d;
    logic                mode_q, mode_d;
    logic [WK_W-1:0]     wake_q;
    logic                cyc_end;
    logic                wait_done, tick;
    logic [BW-1:0]       owed;
    logic                full, overflow, consume;
    logic                work;
    logic                ro_ok;
    logic [ROW_BITS-1:0] row_cur;

    logic                ras_n_q, cas_n_q, row_oe_q, ack_q;
    logic [ROW_BITS-1:0] row_addr_q;

    dram_ref_tick_gen #(
        .WAKE_CYC (WAKE_CYC),
        .REFI_CYC (REFI_CYC)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_done (wait_done),
        .tick      (tick)
    );

    dram_ref_backlog #(
        .MAX_OWED (MAX_OWED)
    ) u_backlog (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .consume  (consume),
        .clear    (overflow),
        .owed     (owed),
        .full     (full),
        .overflow (overflow)
    );

    generate
        if (RAS_ONLY_EN) begin : g_row
            dram_ref_row_ctr #(
                .ROW_BITS (ROW_BITS)
            ) u_row (
                .clk   (clk),
                .rst_n (rst_n),
                .adv   (cyc_end && mode_q),
                .row   (row_cur)
            );
            assign ro_ok = 1'b1;
        end else begin : g_norow
            assign row_cur = '0;
            assign ro_ok   = 1'b0;
        end
    endgenerate

    assign work    = (wake_q != '0) || (owed != '0);
    assign consume = cyc_end && (wake_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        mode_d  = mode_q;
        cyc_end = 1'b0;
        unique case (state_q)
            ST_PWR_WAIT: begin
                if (wait_done) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (ref_gnt && work) begin
                    mode_d = ras_only_sel && ro_ok;
                    if (mode_d) begin
                        state_d = ST_ROW_LEAD;
                        ph_d    = '0;
                    end else begin
                        state_d = ST_CAS_LEAD;
                        ph_d    = PH_W'(CSR_CYC - 1);
                    end
                end
            end
            ST_CAS_LEAD, ST_ROW_LEAD: begin
                if (ph_q == '0) begin
                    state_d = ST_RAS_LOW;
                    ph_d    = PH_W'(RAS_CYC - 1);
                end else begin
                    ph_d = ph_q - 1'b1;
                end
            end
            ST_RAS_LOW: begin
                if (ph_q == '0) begin
                    state_d = ST_PRECHG;
                    ph_d    = PH_W'(RP_CYC - 1);
                end else begin
                    ph_d = ph_q - 1'b1;
                end
            end
            ST_PRECHG: begin
                if (ph_q == '0) begin
                    state_d = ST_IDLE;
                    cyc_end = 1'b1;
                end else begin
                    ph_d = ph_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWR_WAIT;
            ph_q    <= '0;
            mode_q  <= 1'b0;
            wake_q  <= WK_W'(WAKE_CYCLES);
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            mode_q  <= mode_d;
            if (overflow)                  wake_q <= WK_W'(WAKE_CYCLES);
            else if (cyc_end && wake_q != '0) wake_q <= wake_q - 1'b1;
        end
    end

    // registered strobe outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_n_q    <= 1'b1;
            cas_n_q    <= 1'b1;
            row_oe_q   <= 1'b0;
            row_addr_q <= '0;
            ack_q      <= 1'b0;
        end else begin
            ras_n_q    <= (state_d != ST_RAS_LOW);
            cas_n_q    <= !((state_d == ST_CAS_LEAD) ||
                            ((state_d == ST_RAS_LOW) && !mode_d));
            row_oe_q   <= mode_d && ((state_d == ST_ROW_LEAD) || (state_d == ST_RAS_LOW));
            row_addr_q <= (mode_d && ((state_d == ST_ROW_LEAD) || (state_d == ST_RAS_LOW)))
                          ? row_cur : '0;
            ack_q      <= cyc_end;
        end
    end

    assign ref_req    = wait_done && work;
    assign ref_urgent = wait_done && ((wake_q != '0) || full);
    assign init_done  = wait_done && (wake_q == '0);
    assign ref_ack    = ack_q;
    assign ras_n      = ras_n_q;
    assign cas_n      = cas_n_q;
    assign we_n       = 1'b1;
    assign row_oe     = row_oe_q;
    assign row_addr   = row_addr_q;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
    parameter int RAS_CYC = 6,
    parameter int RP_CYC  = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ref_gnt,
    input logic ref_req,
    input logic ref_urgent,
    input logic init_done,
    input logic ras_n,
    input logic cas_n,
    input logic row_oe
);
    logic [15:0] low_cnt, high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= '0;
        end else begin
            low_cnt  <= ras_n ? '0 : low_cnt + 1'b1;
            high_cnt <= !ras_n ? '0 : ((high_cnt == 16'hFFFF) ? high_cnt : high_cnt + 1'b1);
        end
    end

    assert_grant_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(ref_gnt));
    assert_grant_gate_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_oe) |-> $past(ref_gnt));
    assert_cbr_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !row_oe) |-> !cas_n);
    assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_cnt == 16'(RAS_CYC)));
    assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (high_cnt >= 16'(RP_CYC)));
    assert_idle_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_req |-> (ras_n && cas_n));
    assert_urgent_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);
    assert_rewake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_done) |-> ref_urgent);
    assert_rasonly_cas_R11: assert property (@(posedge clk) disable iff (!rst_n)
        row_oe |-> cas_n);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .ref_urgent (ref_urgent),
    .init_done  (init_done),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .row_oe     (row_oe)
);

// File: tb/dram_refresh_sched_test.sv
`timescale 1ns/1ps
module dram_refresh_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int RB         = 3;
    // expected cycle counts, derived from the requirement formulas
    localparam int E_RAS  = (60 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int E_RP   = (40 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int E_CSR  = (15 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int E_WAKE = (500 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int E_REFI = (2000 + CLK_PERIOD - 1) / CLK_PERIOD;

    typedef struct packed { logic ro; logic [RB-1:0] row; } vec_t;
    localparam vec_t VEC [6] = '{
        '{1'b0, 3'd0}, '{1'b1, 3'd0}, '{1'b1, 3'd1},
        '{1'b0, 3'd0}, '{1'b1, 3'd2}, '{1'b0, 3'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0, ras_only_sel = 1'b0;
    logic ref_req, ref_urgent, ref_ack, init_done, ras_n, cas_n, we_n, row_oe;
    logic [RB-1:0] row_addr;

    int n_checks = 0, n_err = 0, cyc = 0;
    int m_cas, m_ras, m_rise, m_ack, m_row, m_oe, m_we_bad, m_to;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_refresh_sched #(
        .CLK_PS (CLK_PERIOD * 1000), .T_RAS_NS (60), .T_RP_NS (40),
        .T_CSR_NS (15), .T_CHR_NS (10), .WAKE_NS (500), .REFI_NS (2000),
        .REFI_MARGIN (0), .WAKE_CYCLES (8), .MAX_OWED (8), .ROW_BITS (RB),
        .RAS_ONLY_EN (1'b1)
    ) uut (
        .clk (clk), .rst_n (rst_n), .ref_gnt (ref_gnt), .ras_only_sel (ras_only_sel),
        .ref_req (ref_req), .ref_urgent (ref_urgent), .ref_ack (ref_ack),
        .init_done (init_done), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .row_oe (row_oe), .row_addr (row_addr)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    endtask

    task automatic wait_sig_req(output int ok);
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            if (ref_req) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    // observes one refresh cycle up to and including its ref_ack
    task automatic measure();
        m_cas = -1; m_ras = -1; m_rise = -1; m_ack = -1;
        m_row = -1; m_oe = -1; m_we_bad = 0; m_to = 1;
        for (int i = 1; i <= 200; i++) begin
            @(negedge clk);
            if (!we_n) m_we_bad = 1;
            if (!cas_n && m_cas < 0) m_cas = i;
            if (!ras_n && m_ras < 0) begin m_ras = i; m_row = int'(row_addr); m_oe = int'(row_oe); end
            if (ras_n && m_ras >= 0 && m_rise < 0) m_rise = i;
            if (ref_ack) begin m_ack = i; m_to = 0; break; end
        end
    endtask

    task automatic check_cycle(input logic ro, input int exp_row);
        check_eq("R3 cycle completed after grant", m_to, 0);
        check_eq("R7 we_n high", m_we_bad, 0);
        check_eq("R5 RAS low width", m_rise - m_ras, E_RAS);
        check_eq("R6 ack after precharge", m_ack - m_rise, E_RP);
        if (!ro) begin
            check_eq("R4 CAS lead before RAS", m_ras - m_cas, E_CSR);
            check_eq("R4 row_oe low in CBR", m_oe, 0);
        end else begin
            check_eq("R11 CAS never low", m_cas, -1);
            check_eq("R11 row_oe at RAS fall", m_oe, 1);
            check_eq("R11 row address", m_row, exp_row);
        end
    endtask

    task automatic refresh_once(input logic ro, input int exp_row);
        int ok;
        wait_sig_req(ok);
        check_eq("R8 refresh owed", ok, 1);
        ras_only_sel = ro;
        ref_gnt = 1'b1;
        measure();
        ref_gnt = 1'b0;
        ras_only_sel = 1'b0;
        check_cycle(ro, exp_row);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int t0, r1, r2, u, f, ok, bad, acks;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq("R1 ras_n in reset", int'(ras_n), 1);
        check_eq("R1 cas_n in reset", int'(cas_n), 1);
        check_eq("R1 ref_req in reset", int'(ref_req), 0);
        check_eq("R1 init_done in reset", int'(init_done), 0);
        rst_n = 1'b1;
        t0 = cyc;
        bad = 0;
        for (int i = 0; i < 2000 && !ref_req; i++) begin
            @(negedge clk);
            if (!ras_n || !cas_n) bad = 1;
        end
        check_eq("R1 pause length", cyc - t0, E_WAKE);
        check_eq("R1 strobes idle in pause", bad, 0);
        check_eq("R9 urgent during wake-up", int'(ref_urgent), 1);
        check_eq("R2 not ready before burst", int'(init_done), 0);

        // R2: power-up burst of eight CBR cycles
        ref_gnt = 1'b1;
        for (int i = 0; i < 8; i++) begin
            measure();
            check_cycle(1'b0, 0);
            check_eq("R2 init_done during burst", int'(init_done), (i == 7) ? 1 : 0);
        end
        ref_gnt = 1'b0;
        check_eq("R8 nothing owed after burst", int'(ref_req), 0);

        // R3: request without grant leaves strobes alone
        wait_sig_req(ok);
        r1 = cyc;
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!ras_n || !cas_n) bad = 1;
        end
        check_eq("R3 no strobe without grant", bad, 0);
        refresh_once(1'b0, 0);
        check_eq("R8 ack retires request", int'(ref_req), 0);
        wait_sig_req(ok);
        r2 = cyc;
        check_eq("R8 refresh period", r2 - r1, E_REFI);

        // vector table: mixed CBR and RAS-only cycles
        for (int v = 0; v < 6; v++) begin
            refresh_once(VEC[v].ro, int'(VEC[v].row));
        end

        // R9/R10: starve the scheduler until retention is lost
        for (int i = 0; i < 3000 && !ref_urgent; i++) @(negedge clk);
        u = cyc;
        check_eq("R9 urgent implies request", int'(ref_req), 1);
        check_eq("R9 still ready at full backlog", int'(init_done), 1);
        for (int i = 0; i < 400 && init_done; i++) @(negedge clk);
        f = cyc;
        check_eq("R10 overflow one period after full", f - u, E_REFI);
        check_eq("R10 urgent held on overflow", int'(ref_urgent), 1);

        // R10/R11: recovery burst in RAS-only mode crosses the row wrap
        ras_only_sel = 1'b1;
        ref_gnt = 1'b1;
        acks = 0;
        for (int i = 0; i < 12 && !init_done; i++) begin
            measure();
            check_cycle(1'b1, (3 + acks) % (1 << RB));
            if (!m_to) acks++;
        end
        ref_gnt = 1'b0;
        ras_only_sel = 1'b0;
        check_eq("R10 burst length", acks, 8);
        check_eq("R10 ready again", int'(init_done), 1);
        @(negedge clk);
        check_eq("R10 backlog cleared", int'(ref_req), 0);

        summary();
        $finish;
    end
endmodule